// File: doc/BRIEF.md
# Clock-Phase-1 Serial Slave Transceiver

This block is the receiving end of a four-wire synchronous serial link. It moves one 8-bit word in each direction per transfer. It runs on the system clock and passes the external shift clock, slave select and master data input through two-stage synchronizers before it looks at any of them. It then classifies each shift-clock transition as a leading edge (leaving the idle level) or a trailing edge (returning to it). Outgoing data changes on leading edges and incoming data is sampled on trailing edges. Leading edges are edge numbers 1, 3 … 15 of a transfer and trailing edges are 2, 4 … 16.

A transfer is delimited by counting sixteen clock edges, not by the select line. Select may therefore stay low across any number of consecutive words, or be tied low permanently. A host loads the outgoing word through a parallel write strobe. It collects the incoming word from a parallel output and acknowledges it with a read strobe, which clears the completion flag. A control input sets the idle level of the clock, and another sets the bit order for both directions.

Top module: `spi_cpha1_slave`

## Requirements
- R1: After reset, `xfer_done` is 0, `rx_word` is 0 and `miso_en` is 0.
- R2: While the synchronized select is high, `miso_en` is 0 and the edge count returns to the start of a word. A word cut short by select rising is discarded, and the next word is received complete.
- R3: With `lsb_first` = 0, `miso_o` presents bit 7 of the transmit word first, then bits 6 down to 0. It changes only after leading clock edges.
- R4: `mosi_i` is sampled on trailing clock edges, and the eight samples form `rx_word`. With `lsb_first` = 0, the first sample becomes bit 7.
- R5: With `lsb_first` = 1, both directions run bit 0 first: the first bit out on `miso_o` is bit 0, and the first sample taken becomes bit 0 of `rx_word`.
- R6: `idle_high` = 0 means the clock idles low, so a rising transition is leading. `idle_high` = 1 means it idles high, so a falling transition is leading. Both settings give identical data.
- R7: A word ends on the 16th clock edge (the 8th trailing edge). Select may stay low between words, and back-to-back words are each received and flagged.
- R8: `xfer_done` rises about half a clock period after the 16th edge. The block measures the spacing between edges 15 and 16 and waits that long. If the next word's first edge arrives first, the flag is set at once.
- R9: The transmit word held at the first leading edge of a word is the word sent. When no new `tx_load` occurred, the previous word is sent again.
- R10: A `rx_take` pulse clears `xfer_done`. A completion in the same cycle wins over the clear.
- R11: Clock transitions while select is high have no effect on the edge count, the flag or the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck_i | input | 1 | Serial shift clock from the master (asynchronous) |
| sel_n_i | input | 1 | Slave select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| idle_high | input | 1 | Clock idle level: 0 low, 1 high |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| tx_word | input | 8 | Word to transmit |
| tx_load | input | 1 | Write strobe that stores `tx_word` |
| rx_word | output | 8 | Last completely received word |
| rx_take | input | 1 | Read strobe that clears `xfer_done` |
| xfer_done | output | 1 | Transfer-complete flag |
| miso_o | output | 1 | Serial data to the master |
| miso_en | output | 1 | Output enable for `miso_o` (0 = high impedance) |

## Verification
Every combination of clock idle level and bit order is driven with 64 pairs of transmit and receive words built arithmetically. Each word pair carries distinct bit patterns, so a swapped bit order, a wrong edge classification or an off-by-one shift shows up as a mismatched byte. The flag is sampled both shortly after the 16th edge and after half a clock period. This separates a correctly delayed flag from one set on the edge itself or one that never comes. Separate sequences hold select low across three words with and without new transmit data. They also abort a word halfway and toggle the clock with select high. These distinguish edge-count framing from select framing and show that stray edges are ignored.

// File: rtl/spi_s_pkg.sv
package spi_s_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } sck_ev_t;
endpackage

// File: rtl/spi_s_sync.sv
module spi_s_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rst_val,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{rst_val[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_s_edge.sv
module spi_s_edge
  import spi_s_pkg::*;
#(
  parameter int W     = 8,
  parameter int GAP_W = 8,
  localparam int CW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             sel_s,
  input  logic             idle_high,
  output sck_ev_t          ev,
  output logic             first_lead,
  output logic             frame_done,
  output logic [GAP_W-1:0] gap
);
  logic          sck_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_d;

  always_comb begin
    ev.lead  = !sel_s && (sck_q == idle_high) && (sck_s != idle_high);
    ev.trail = !sel_s && (sck_q != idle_high) && (sck_s == idle_high);
    first_lead = ev.lead && (cnt_q == '0);
    frame_done = ev.trail && (cnt_q == CW'(W-1));
    cnt_d = cnt_q;
    if (sel_s)         cnt_d = '0;
    else if (ev.trail) cnt_d = (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
    gap_d = gap;
    if (ev.lead || ev.trail) gap_d = '0;
    else if (gap != '1)      gap_d = gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
      gap   <= '0;
    end else begin
      sck_q <= sck_s;
      cnt_q <= cnt_d;
      gap   <= gap_d;
    end
  end

  AST_SEL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (cnt_q == '0)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
endmodule

// File: rtl/spi_s_shift.sv
module spi_s_shift
  import spi_s_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sck_ev_t      ev,
  input  logic         first_lead,
  input  logic         lsb_first,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_hold,
  output logic         tx_bit,
  output logic [W-1:0] rx_sh
);
  logic [W-1:0] tx_sh, tx_d, rx_d;

  always_comb begin
    tx_d = tx_sh;
    if (first_lead)   tx_d = tx_hold;
    else if (ev.lead) tx_d = lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
    rx_d = rx_sh;
    if (ev.trail)     rx_d = lsb_first ? {mosi_s, rx_sh[W-1:1]} : {rx_sh[W-2:0], mosi_s};
    tx_bit = lsb_first ? tx_sh[0] : tx_sh[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      tx_sh <= tx_d;
      rx_sh <= rx_d;
    end
  end

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.lead |=> $stable(tx_sh)); // R3
  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.trail |=> $stable(rx_sh)); // R4
endmodule

// File: rtl/spi_cpha1_slave.sv
module spi_cpha1_slave
  import spi_s_pkg::*;
#(
  parameter int W     = 8,
  parameter int GAP_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_i,
  input  logic         sel_n_i,
  input  logic         mosi_i,
  input  logic         idle_high,
  input  logic         lsb_first,
  input  logic [W-1:0] tx_word,
  input  logic         tx_load,
  output logic [W-1:0] rx_word,
  input  logic         rx_take,
  output logic         xfer_done,
  output logic         miso_o,
  output logic         miso_en
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       sck_s, sel_s, mosi_s;
  sck_ev_t    ev;
  logic       first_lead, frame_done, frame_done_q;
  logic [GAP_W-1:0] gap;
  logic [W-1:0] tx_hold, rx_sh, rx_word_d;
  logic       pend_q, pend_d, done_d, set_flag;
  logic [GAP_W-1:0] dly_q, dly_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_s_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sn), .rst_val(3'b010),
    .d({sck_i, sel_n_i, mosi_i}), .q({sck_s, sel_s, mosi_s}));

  spi_s_edge #(.W(W), .GAP_W(GAP_W)) u_edge (
    .clk(clk), .rst_n(rst_sn), .sck_s(sck_s), .sel_s(sel_s),
    .idle_high(idle_high), .ev(ev), .first_lead(first_lead),
    .frame_done(frame_done), .gap(gap));

  spi_s_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_sn), .ev(ev), .first_lead(first_lead),
    .lsb_first(lsb_first), .mosi_s(mosi_s), .tx_hold(tx_hold),
    .tx_bit(miso_o), .rx_sh(rx_sh));

  assign miso_en = !sel_s;

  always_comb begin
    pend_d   = pend_q;
    dly_d    = dly_q;
    set_flag = 1'b0;
    if (pend_q) begin
      if (dly_q == '0 || ev.lead) begin
        pend_d   = 1'b0;
        set_flag = 1'b1;
      end else begin
        dly_d = dly_q - 1'b1;
      end
    end
    if (frame_done) begin
      pend_d = 1'b1;
      dly_d  = gap;
    end
    done_d = xfer_done;
    if (set_flag)     done_d = 1'b1;
    else if (rx_take) done_d = 1'b0;
    rx_word_d = frame_done_q ? rx_sh : rx_word;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_hold      <= '0;
      rx_word      <= '0;
      frame_done_q <= 1'b0;
      pend_q       <= 1'b0;
      dly_q        <= '0;
      xfer_done    <= 1'b0;
    end else begin
      if (tx_load) tx_hold <= tx_word;
      rx_word      <= rx_word_d;
      frame_done_q <= frame_done;
      pend_q       <= pend_d;
      dly_q        <= dly_d;
      xfer_done    <= done_d;
    end
  end

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(xfer_done) |-> $past(pend_q)); // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    (xfer_done && rx_take && !pend_q) |=> !xfer_done); // R10
  AST_WORD_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    !frame_done_q |=> $stable(rx_word)); // R4
endmodule

// File: tb/spi_cpha1_slave_bench.sv
module spi_cpha1_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n, sck, sel_n, mosi, idle_high, lsb_first, tx_load, rx_take;
  logic [7:0] tx_word, rx_word;
  logic xfer_done, miso_o, miso_en;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cpha1_slave u_spi_cpha1_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .mosi_i(mosi),
    .idle_high(idle_high), .lsb_first(lsb_first), .tx_word(tx_word),
    .tx_load(tx_load), .rx_word(rx_word), .rx_take(rx_take),
    .xfer_done(xfer_done), .miso_o(miso_o), .miso_en(miso_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk); tx_word = v; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); rx_take = 1'b1;
    @(negedge clk); rx_take = 1'b0;
  endtask

  // one bit: leading edge drives mosi, miso sampled just before trailing edge
  task automatic bitx(input logic mo, input bit last, output logic mi);
    @(negedge clk); sck = ~idle_high; mosi = mo;
    wclk(H);
    mi = miso_o;
    sck = idle_high;
    if (!last) wclk(H);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input string tg);
    logic b;
    mi = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bitx(lsb_first ? mo[i] : mo[7-i], i == 7, b);
      if (lsb_first) mi[i] = b; else mi[7-i] = b;
    end
    wclk(4);
    chk({"R8 flag early ", tg}, xfer_done, 0);
    wclk(H + 2);
    chk({"R8 R7 flag set ", tg}, xfer_done, 1);
  endtask

  task automatic sel(input logic v);
    @(negedge clk); sel_n = v;
    wclk(4);
  endtask

  initial begin
    logic [7:0] mi, txv, mov;
    rst_n = 1'b0; sck = 1'b0; sel_n = 1'b1; mosi = 1'b0; idle_high = 1'b0;
    lsb_first = 1'b0; tx_load = 1'b0; rx_take = 1'b0; tx_word = 8'h00;
    wclk(4); rst_n = 1'b1; wclk(4);
    chk("R1 flag", xfer_done, 0);
    chk("R1 rx_word", rx_word, 0);
    chk("R1 miso_en", miso_en, 0);

    // sweep of idle level and bit order
    for (int cfg = 0; cfg < 4; cfg++) begin
      idle_high = cfg[0]; lsb_first = cfg[1]; sck = cfg[0];
      wclk(6);
      for (int k = 0; k < 64; k++) begin
        txv = 8'((k * 37 + cfg * 11) ^ 8'h5A);
        mov = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 53 + cfg * 7) & 255);
        load_tx(txv);
        sel(1'b0);
        chk("R2 miso_en when selected", miso_en, 1);
        xfer(mov, mi, "sweep");
        chk(lsb_first ? "R5 R6 R4 rx order" : "R4 R6 rx order", rx_word, mov);
        chk(lsb_first ? "R5 R6 R3 tx order" : "R3 R6 tx order", mi, txv);
        take();
        chk("R10 flag cleared", xfer_done, 0);
        sel(1'b1);
        chk("R2 miso released", miso_en, 0);
      end
    end

    // back-to-back with select held low
    idle_high = 1'b0; lsb_first = 1'b0; sck = 1'b0; wclk(6);
    load_tx(8'hC3);
    sel(1'b0);
    xfer(8'h96, mi, "b2b1");
    chk("R7 b2b word1 rx", rx_word, 8'h96);
    chk("R7 b2b word1 tx", mi, 8'hC3);
    take();
    load_tx(8'h3C);
    xfer(8'h69, mi, "b2b2");
    chk("R7 b2b word2 rx", rx_word, 8'h69);
    chk("R7 R9 b2b word2 tx", mi, 8'h3C);
    take();
    xfer(8'h12, mi, "b2b3");
    chk("R7 b2b word3 rx", rx_word, 8'h12);
    chk("R9 resend without load", mi, 8'h3C);
    take();
    chk("R7 miso_en held", miso_en, 1);

    // word aborted by select rising
    for (int i = 0; i < 3; i++) bitx(1'b1, 1'b0, mi[0]);
    sel(1'b1);
    chk("R2 released after abort", miso_en, 0);
    wclk(2 * H);
    chk("R2 no flag after abort", xfer_done, 0);
    chk("R2 rx_word kept after abort", rx_word, 8'h12);
    load_tx(8'hA1);
    sel(1'b0);
    xfer(8'h4E, mi, "abort");
    chk("R2 rx after abort", rx_word, 8'h4E);
    chk("R2 tx after abort", mi, 8'hA1);
    take();
    sel(1'b1);

    // clock toggling with select high
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sck = ~sck; mosi = ~mosi; wclk(H);
    end
    if (sck != idle_high) begin @(negedge clk); sck = idle_high; wclk(H); end
    chk("R11 no flag while deselected", xfer_done, 0);
    chk("R11 rx_word unchanged", rx_word, 8'h4E);
    load_tx(8'h77);
    sel(1'b0);
    xfer(8'hB4, mi, "desel");
    chk("R11 rx after stray edges", rx_word, 8'hB4);
    chk("R11 tx after stray edges", mi, 8'h77);
    sel(1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule